// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the system clock and marks, one system cycle at a time, where the transfer engine must shift out its next bit and where it must capture an incoming one. A five-bit divider code sets the serial clock period. Its lower half is linear. Its upper half gives only even ratios, which doubles the reach without adding a bit. Clock polarity sets the idle level. Clock phase decides whether capture happens on the leading or on the trailing edge of each period. A capture-edge control moves the capture point to the other edge. It applies only at the two fastest ratios, where the returning data arrives late relative to the edge.

A sequencer with four states drives the outputs. IDLE holds the clock at its idle level. LEAD covers the first half of a period, with the clock at the non-idle level. TRAIL covers the second half, with the clock back at the idle level. FAST is the divide-by-one mode, in which every system cycle is both a shift and a capture slot. The named transitions are: start (IDLE to LEAD, or IDLE to FAST), half (LEAD to TRAIL), wrap (TRAIL to LEAD, or TRAIL to FAST, which begins the next period and loads the divider code again), retune (FAST to LEAD when the code leaves divide-by-one), and stop (any state to IDLE when the enable falls). The divider code is loaded only at start, wrap and retune, so a code written during a period takes effect at the next period boundary.

Top module: `spi_clk_divider`

## Requirements
- R1: Codes 1 to 15, with bit 4 of the code clear, give a serial clock period of that many system cycles, measured between consecutive leading edges.
- R2: Codes 17 to 31, with bit 4 of the code set, give a period of twice the value in bits 3:0, so the even ratios 2 to 30 are covered.
- R3: Codes 0 and 16 select divide-by-one. In this mode shift_en and sample_en are both high in every enabled cycle, and sclk stays at its idle level.
- R4: For an odd ratio N, sclk is high for (N+1)/2 cycles and low for (N-1)/2 cycles. For an even ratio the two halves are equal.
- R5: While the block is disabled, sclk equals cpol. The first leading edge (sclk leaving the idle level) appears one cycle after enable is first sampled high.
- R6: With cpha=0, sample_en pulses in the cycle of each leading edge and shift_en in the cycle of each trailing edge. With cpha=1 the roles are swapped. In no other cycle are they high.
- R7: When the ratio is 2 or less and capt_edge=1, sample_en moves to the opposite edge, the same edge as shift_en. For ratios above 2, capt_edge has no effect.
- R8: A change of the divider code during a period leaves that period unchanged. The new ratio applies from the next leading edge.
- R9: When enable drops, sclk returns to cpol and both enables stay low from the next cycle on, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the serial clock while high |
| div_code | input | CODE_W (5) | Divider code, split encoding |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0: capture on the leading edge; 1: capture on the trailing edge |
| capt_edge | input | 1 | Move capture to the other edge at ratios of 2 or less |
| sclk | output | 1 | Serial clock |
| shift_en | output | 1 | One-cycle pulse: present the next output bit |
| sample_en | output | 1 | One-cycle pulse: capture the input bit |

## Verification
The bench aims at the split code boundaries: 0, 15, 16, 17 and 31. A decoder that treats the upper half as linear gives periods of 17 to 31 instead of the even ratios, and one that mishandles 0 or 16 stalls or emits a zero-length phase. Odd ratios in both polarities show whether the extra cycle lands on the high half. A swap there moves every trailing edge by a cycle. The capture-edge bit is applied both at ratio 2, where the sample pulse must move to the shift edge, and at ratios 3 and 15, where a design that ignores the ratio limit would move it wrongly. A code rewritten inside a period and an enable dropped mid-period catch designs that retune immediately or that let sclk linger at the active level.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_FAST  = 2'd3
    } clkdiv_state_e;

endpackage

// File: rtl/spi_clk_ratio_dec.sv
module spi_clk_ratio_dec #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] ratio
);
    localparam int LOW_W = CODE_W - 1;

    logic [LOW_W-1:0]  low_part;
    logic [CODE_W-1:0] raw_ratio;

    assign low_part = code[LOW_W-1:0];

    // Upper half of the code space doubles the low bits; lower half is linear.
    always_comb begin
        if (code[CODE_W-1]) begin
            raw_ratio = {low_part, 1'b0};
        end else begin
            raw_ratio = code;
        end
    end

    // A zero result (codes 0 and 16) means divide-by-one.
    assign ratio = (raw_ratio == '0) ? CODE_W'(1) : raw_ratio;

    always_comb begin
        assert_ratio_nonzero_R3: assert (ratio != '0);
    end

endmodule

// File: rtl/spi_clk_phase_fsm.sv
module spi_clk_phase_fsm
    import spi_clk_div_pkg::*;
#(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cpol,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               sclk_q,
    output logic               lead_q,
    output logic               trail_q,
    output logic               fast_q,
    output logic [RATIO_W-1:0] ratio_q
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    clkdiv_state_e      state_q;
    clkdiv_state_e      state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic               enter_lead;
    logic               enter_trail;
    logic               enter_fast;
    logic [RATIO_W-1:0] lead_cnt_init;
    logic [RATIO_W-1:0] trail_cnt_init;

    // Length of the first half: the high half takes the odd cycle.
    function automatic logic [RATIO_W-1:0] lead_len(
        input logic [RATIO_W-1:0] n,
        input logic               pol
    );
        logic [RATIO_W-1:0] half_dn;
        half_dn = n >> 1;
        return pol ? half_dn : (n - half_dn);
    endfunction

    assign lead_cnt_init  = lead_len(ratio_in, cpol) - ONE;
    assign trail_cnt_init = ratio_q - lead_len(ratio_q, cpol) - ONE;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = (ratio_in == ONE) ? ST_FAST : ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = (ratio_in == ONE) ? ST_FAST : ST_LEAD;
                end
            end
            ST_FAST: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (ratio_in != ONE) begin
                    state_d = ST_LEAD;
                end
            end
        endcase
    end

    assign enter_lead  = (state_d == ST_LEAD)  && (state_q != ST_LEAD);
    assign enter_trail = (state_d == ST_TRAIL) && (state_q != ST_TRAIL);
    assign enter_fast  = (state_d == ST_FAST)  && (state_q != ST_FAST);

    // State register with the phase counter and the held ratio.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ratio_q <= ONE;
        end else begin
            state_q <= state_d;
            if (enter_lead) begin
                cnt_q   <= lead_cnt_init;
                ratio_q <= ratio_in;
            end else if (enter_trail) begin
                cnt_q <= trail_cnt_init;
            end else if (enter_fast) begin
                cnt_q   <= '0;
                ratio_q <= ratio_in;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            fast_q  <= 1'b0;
        end else begin
            sclk_q  <= (state_d == ST_LEAD) ? ~cpol : cpol;
            lead_q  <= enter_lead;
            trail_q <= enter_trail;
            fast_q  <= (state_d == ST_FAST);
        end
    end

    assert_edge_kinds_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_q, trail_q, fast_q}));

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (sclk_q == $past(cpol) && !lead_q && !trail_q && !fast_q));

    assert_no_double_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lead_q |=> !lead_q);

    assert_ratio_only_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q != $past(ratio_q)) |-> (lead_q || fast_q));

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD || state_q == ST_TRAIL) |-> (cnt_q < ratio_q));

    assert_toggle_marks_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $stable(cpol) && sclk_q != $past(sclk_q)) |-> (lead_q || trail_q));

endmodule

// File: rtl/spi_clk_edge_map.sv
module spi_clk_edge_map #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lead,
    input  logic               trail,
    input  logic               fast,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               cpha,
    input  logic               capt_edge,
    output logic               shift_en,
    output logic               sample_en
);
    localparam logic [RATIO_W-1:0] CAPT_LIMIT = RATIO_W'(2);

    logic capt_active;
    logic sample_on_trail;

    assign capt_active     = capt_edge && (ratio <= CAPT_LIMIT);
    assign sample_on_trail = cpha ^ capt_active;

    always_comb begin
        shift_en  = fast | (cpha ? lead : trail);
        sample_en = fast | (sample_on_trail ? trail : lead);
    end

    assert_shared_edge_only_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && sample_en) |-> (ratio <= CAPT_LIMIT));

    assert_no_pulse_between_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lead && !trail && !fast) |-> (!shift_en && !sample_en));

endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] div_code,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              capt_edge,
    output logic              sclk,
    output logic              shift_en,
    output logic              sample_en
);
    localparam int RATIO_W = CODE_W;

    logic [RATIO_W-1:0] ratio_dec;
    logic [RATIO_W-1:0] ratio_held;
    logic               lead_p;
    logic               trail_p;
    logic               fast_p;

    spi_clk_ratio_dec #(
        .CODE_W (CODE_W)
    ) u_dec (
        .code  (div_code),
        .ratio (ratio_dec)
    );

    spi_clk_phase_fsm #(
        .RATIO_W (RATIO_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cpol     (cpol),
        .ratio_in (ratio_dec),
        .sclk_q   (sclk),
        .lead_q   (lead_p),
        .trail_q  (trail_p),
        .fast_q   (fast_p),
        .ratio_q  (ratio_held)
    );

    spi_clk_edge_map #(
        .RATIO_W (RATIO_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead      (lead_p),
        .trail     (trail_p),
        .fast      (fast_p),
        .ratio     (ratio_held),
        .cpha      (cpha),
        .capt_edge (capt_edge),
        .shift_en  (shift_en),
        .sample_en (sample_en)
    );

endmodule

// File: tb/spi_clk_divider_tb.sv
`timescale 1ns/1ps
module spi_clk_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] div_code = 5'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       capt_edge = 1'b0;
    logic       sclk;
    logic       shift_en;
    logic       sample_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_clk_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .div_code  (div_code),
        .cpol      (cpol),
        .cpha      (cpha),
        .capt_edge (capt_edge),
        .sclk      (sclk),
        .shift_en  (shift_en),
        .sample_en (sample_en)
    );

    // Fields: [12:8] code, [7] cpol, [6] cpha, [5] capt_edge, [4:0] expected ratio
    localparam int NVEC = 12;
    localparam logic [12:0] VEC [NVEC] = '{
        {5'd3,  1'b0, 1'b0, 1'b0, 5'd3},
        {5'd3,  1'b1, 1'b1, 1'b1, 5'd3},
        {5'd7,  1'b0, 1'b0, 1'b0, 5'd7},
        {5'd17, 1'b0, 1'b0, 1'b0, 5'd2},
        {5'd17, 1'b0, 1'b0, 1'b1, 5'd2},
        {5'd17, 1'b1, 1'b1, 1'b1, 5'd2},
        {5'd31, 1'b1, 1'b1, 1'b0, 5'd30},
        {5'd20, 1'b0, 1'b0, 1'b0, 5'd8},
        {5'd0,  1'b0, 1'b0, 1'b0, 5'd1},
        {5'd16, 1'b1, 1'b1, 1'b1, 5'd1},
        {5'd15, 1'b0, 1'b0, 1'b1, 5'd15},
        {5'd2,  1'b1, 1'b1, 1'b0, 5'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input logic [12:0] v);
        int n;
        bit pol;
        bit pha;
        bit capt_act;
        bit sal;
        int leads[3];
        int nlead;
        int lead_dur;
        int bad;
        logic prev;
        n   = int'(v[4:0]);
        pol = v[7];
        pha = v[6];
        capt_act = v[5] && (n <= 2);
        sal = !(pha ^ capt_act);
        go_idle();
        div_code = v[12:8];
        cpol = v[7];
        cpha = v[6];
        capt_edge = v[5];
        @(negedge clk);
        @(negedge clk);
        // R9: disabled output follows cpol with no pulses
        chk(sclk == pol && !shift_en && !sample_en, "R9 idle level", int'(sclk), int'(pol));
        en = 1'b1;
        if (n == 1) begin
            bad = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (sclk != pol || !shift_en || !sample_en) bad++;
            end
            chk(bad == 0, "R3 divide-by-one pulses", bad, 0);
        end else begin
            nlead = 0;
            lead_dur = -1;
            bad = 0;
            prev = pol;
            leads[0] = -1;
            leads[1] = -1;
            leads[2] = -1;
            for (int i = 0; i < 2 * n + 2; i++) begin
                bit lt;
                bit tt;
                bit esh;
                bit esa;
                @(negedge clk);
                lt = (sclk != prev) && (sclk == !pol);
                tt = (sclk != prev) && (sclk == pol);
                if (lt) begin
                    if (nlead < 3) leads[nlead] = i;
                    nlead++;
                end
                if (tt && nlead == 1 && lead_dur < 0) lead_dur = i - leads[0];
                esh = lt ? pha : (tt ? !pha : 1'b0);
                esa = lt ? sal : (tt ? !sal : 1'b0);
                if (shift_en != esh || sample_en != esa) bad++;
                prev = sclk;
            end
            chk(leads[0] == 0, "R5 first leading edge latency", leads[0], 0);
            chk(leads[1] - leads[0] == n, v[12] ? "R2 even period" : "R1 linear period",
                leads[1] - leads[0], n);
            chk(lead_dur == (pol ? n / 2 : n - n / 2), "R4 phase split", lead_dur,
                pol ? n / 2 : n - n / 2);
            chk(bad == 0, v[5] ? "R7 capture edge placement" : "R6 edge placement", bad, 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk(sclk == 1'b0 && !shift_en && !sample_en, "R9 reset outputs", int'(sclk), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VEC[k]);
        end

        // R8: code change mid-period applies at the next leading edge
        begin
            int leads[3];
            int nl;
            logic prev;
            go_idle();
            cpol = 1'b0; cpha = 1'b0; capt_edge = 1'b0; div_code = 5'd4;
            @(negedge clk);
            en = 1'b1;
            nl = 0;
            prev = 1'b0;
            leads[0] = -1; leads[1] = -1; leads[2] = -1;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (i == 0) div_code = 5'd6;
                if (sclk && !prev) begin
                    if (nl < 3) leads[nl] = i;
                    nl++;
                end
                prev = sclk;
            end
            chk(leads[1] - leads[0] == 4, "R8 current period kept", leads[1] - leads[0], 4);
            chk(leads[2] - leads[1] == 6, "R8 new ratio next period", leads[2] - leads[1], 6);
        end

        // R9: enable dropped inside the active half of a period
        begin
            int bad;
            go_idle();
            cpol = 1'b0; cpha = 1'b0; capt_edge = 1'b0; div_code = 5'd8;
            @(negedge clk);
            en = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(sclk == 1'b1, "R9 active before drop", int'(sclk), 1);
            en = 1'b0;
            bad = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (sclk != 1'b0 || shift_en || sample_en) bad++;
            end
            chk(bad == 0, "R9 idle after mid-period drop", bad, 0);
        end

        // R9 with cpol=1: idle level high after a drop
        begin
            go_idle();
            cpol = 1'b1; cpha = 1'b1; div_code = 5'd5;
            @(negedge clk);
            en = 1'b1;
            @(negedge clk);
            chk(sclk == 1'b0, "R5 leading edge falls for cpol=1", int'(sclk), 0);
            en = 1'b0;
            @(negedge clk);
            chk(sclk == 1'b1 && !shift_en && !sample_en, "R9 idle high after drop", int'(sclk), 1);
        end

        finish_run();
    end

endmodule